// File: doc/BRIEF.md
# Coin Reception Controller

This block is a clocked Moore state machine that tallies coins until a fixed price of 35 cents has been collected. Each clock cycle it samples a dime pulse, a quarter pulse and a synchronous reset. It keeps the running total as one of six values: 0, 10, 20, 25, 30 or 35 cents. Once 35 cents is reached the total saturates there, and any overpayment is absorbed without being recorded.

The single output, `paid`, is decoded from the registered total alone. It is high exactly while the total is 35 cents. The state register is three bits wide. Its codes are chosen so that the most significant bit is set for the two top totals; the decode adds the least significant bit to single out 35 cents. The two unused codes fall back to the zero total on the next clock.

Change return, coin validation, sensor debouncing and dispensing sit in the surrounding logic. All pins are plain control levels sampled on the rising clock edge; there is no data stream and no handshake.

Top module: `coin_acceptor`

## Requirements
- R1: While and after reset is held, `paid` is 0 and the total is 0 cents, so exactly four dime cycles are then needed before `paid` rises.
- R2: Reset is synchronous and takes priority over both coin inputs sampled in the same cycle; from every total it returns the machine to 0 cents.
- R3: A cycle with no coin and no reset leaves the total unchanged.
- R4: A dime advances the total 0→10→20→30→35 cents.
- R5: A quarter from 0 cents moves the total to 25 cents.
- R6: A quarter from 10 or from 20 cents moves the total straight to 35 cents.
- R7: From 25 or 30 cents, either coin moves the total to 35 cents.
- R8: At 35 cents any further dime or quarter keeps the total at 35 cents and `paid` stays 1.
- R9: When dime and quarter are both high in one cycle, the quarter is counted and the dime is ignored; from 0 cents this gives 25 cents, not 10 or 35.
- R10: `paid` is 1 exactly when the total is 35 cents and 0 for every other total, 30 cents included, although the 30-cent code shares the set upper bit (codes: 0=000, 10=001, 20=010, 25=011, 30=100, 35=101).
- R11: `paid` is a Moore output: it does not react to coin inputs within a cycle and changes only after the rising clock edge that registers the completing coin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset to the 0-cent total, highest priority |
| dime | input | 1 | One-cycle pulse: a 10-cent coin was accepted |
| quarter | input | 1 | One-cycle pulse: a 25-cent coin was accepted |
| paid | output | 1 | High while the collected total is 35 cents |

## Verification
The bench reaches each of the six totals by its own coin path. In each it applies every combination of idle, dime, quarter, both coins and reset with and without coins, and compares the result with a reference table written from the requirements. Because only `paid` is visible, each resulting total is then identified by how many dimes it takes to reach payment. This separates 0, 10 and 20 cents from one another and from the 25/30 group and from 35 cents, so a wrong transition, lost saturation or wrong coin priority each shows up as a different count. Separate directed sequences check the exact cycle in which `paid` rises, that 30 cents does not set `paid`, and that a coin pulse held before the edge has no effect on the output.

// File: rtl/coin_fsm_pkg.sv
package coin_fsm_pkg;

  localparam int STATE_W = 3;

  // Running total codes; the upper bit marks the two highest totals.
  typedef enum logic [STATE_W-1:0] {
    TOT_0  = 3'b000,
    TOT_10 = 3'b001,
    TOT_20 = 3'b010,
    TOT_25 = 3'b011,
    TOT_30 = 3'b100,
    TOT_35 = 3'b101
  } total_e;

  localparam logic [STATE_W-1:0] TOTAL_RESET = TOT_0;
  localparam int TOP_BIT = STATE_W - 1;

endpackage

// File: rtl/coin_next_state.sv
module coin_next_state
  import coin_fsm_pkg::*;
(
  input  logic [STATE_W-1:0] total_q,
  input  logic               dime,
  input  logic               quarter,
  output logic [STATE_W-1:0] total_d
);

  // A quarter outranks a dime in the same cycle; unused codes recover to zero.
  always_comb begin
    total_d = total_q;
    case (total_q)
      TOT_0: begin
        if (quarter)   total_d = TOT_25;
        else if (dime) total_d = TOT_10;
      end
      TOT_10: begin
        if (quarter)   total_d = TOT_35;
        else if (dime) total_d = TOT_20;
      end
      TOT_20: begin
        if (quarter)   total_d = TOT_35;
        else if (dime) total_d = TOT_30;
      end
      TOT_25, TOT_30: begin
        if (quarter || dime) total_d = TOT_35;
      end
      TOT_35: total_d = TOT_35;
      default: total_d = TOT_0;
    endcase
  end

endmodule

// File: rtl/coin_state_reg.sv
module coin_state_reg #(
  parameter int              W       = 3,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  // Synchronous reset wins over whatever the next-state logic proposes.
  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= d;
  end

endmodule

// File: rtl/coin_paid_decode.sv
module coin_paid_decode
  import coin_fsm_pkg::*;
(
  input  logic [STATE_W-1:0] total_q,
  output logic               paid
);

  // The upper bit alone covers 30 and 35 cents; bit 0 separates them.
  assign paid = total_q[TOP_BIT] & total_q[0];

endmodule

// File: rtl/coin_acceptor.sv
module coin_acceptor
  import coin_fsm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic dime,
  input  logic quarter,
  output logic paid
);

  logic [STATE_W-1:0] total_q;
  logic [STATE_W-1:0] total_d;

  coin_next_state u_next (
    .total_q (total_q),
    .dime    (dime),
    .quarter (quarter),
    .total_d (total_d)
  );

  coin_state_reg #(
    .W       (STATE_W),
    .RST_VAL (TOTAL_RESET)
  ) u_reg (
    .clk (clk),
    .rst (rst),
    .d   (total_d),
    .q   (total_q)
  );

  coin_paid_decode u_dec (
    .total_q (total_q),
    .paid    (paid)
  );

  // R2: reset beats coins
  a_r2_reset_priority: assert property (@(posedge clk)
    rst |=> (total_q == TOT_0));

  // R3: idle cycles hold a legal total
  a_r3_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!dime && !quarter && total_q[TOP_BIT -: 2] != 2'b11) |=> $stable(total_q));

  // R7: one more coin from 25 or 30 cents completes payment
  a_r7_last_coin_pays: assert property (@(posedge clk) disable iff (rst)
    ((total_q == TOT_25 || total_q == TOT_30) && (dime || quarter)) |=> paid);

  // R8: the total saturates at 35 cents
  a_r8_saturates: assert property (@(posedge clk) disable iff (rst)
    (total_q == TOT_35) |=> (total_q == TOT_35));

  // R9: quarter counted, dime dropped
  a_r9_quarter_wins: assert property (@(posedge clk) disable iff (rst)
    (dime && quarter && total_q == TOT_0) |=> (total_q == TOT_25));

  // R11: paid only rises after a registered coin
  a_r11_paid_rises_on_coin: assert property (@(posedge clk) disable iff (rst)
    $rose(paid) |-> ($past(dime) || $past(quarter)));

endmodule

// File: tb/test_coin_acceptor.sv
`timescale 1ns/100ps
module test_coin_acceptor;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dime = 1'b0;
  logic quarter = 1'b0;
  logic paid;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  coin_acceptor i_coin_acceptor (
    .clk     (clk),
    .rst     (rst),
    .dime    (dime),
    .quarter (quarter),
    .paid    (paid)
  );

  task automatic check(input string tag, input int actual, input int expected, input string what);
    n_checks++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, actual, expected);
    end
  endtask

  task automatic step(input logic d, input logic q, input logic r);
    @(negedge clk);
    dime = d; quarter = q; rst = r;
    @(posedge clk);
    #1;
    dime = 1'b0; quarter = 1'b0; rst = 1'b0;
  endtask

  // Reference transitions written from the requirements
  function automatic int ref_next(input int c, input bit d, input bit q, input bit r);
    if (r) return 0;
    if (q) return (c == 0) ? 25 : 35;
    if (d) begin
      case (c)
        0:  return 10;
        10: return 20;
        20: return 30;
        default: return 35;
      endcase
    end
    return c;
  endfunction

  function automatic int dimes_to_pay(input int c);
    case (c)
      0:  return 4;
      10: return 3;
      20: return 2;
      25, 30: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int cents_of(input int idx);
    case (idx)
      0: return 0;
      1: return 10;
      2: return 20;
      3: return 25;
      4: return 30;
      default: return 35;
    endcase
  endfunction

  task automatic reach(input int c);
    step(0, 0, 1);
    case (c)
      10: step(1, 0, 0);
      20: begin step(1, 0, 0); step(1, 0, 0); end
      25: step(0, 1, 0);
      30: begin step(1, 0, 0); step(1, 0, 0); step(1, 0, 0); end
      35: begin step(0, 1, 0); step(1, 0, 0); end
      default: ;
    endcase
  endtask

  task automatic probe(input string tag, input int expected_total);
    int count = 0;
    for (int k = 0; k < 5; k++) begin
      if (paid) break;
      step(1, 0, 0);
      count++;
    end
    check(tag, count, dimes_to_pay(expected_total), "dimes needed to pay");
  endtask

  function automatic string tag_for(input int c, input bit d, input bit q, input bit r);
    if (r) return (d || q) ? "R2" : "R1";
    if (!d && !q) return "R3";
    if (c == 35) return "R8";
    if (d && q) return "R9";
    if (c == 25 || c == 30) return "R7";
    if (q) return (c == 0) ? "R5" : "R6";
    return "R4";
  endfunction

  // R1: reset state
  task automatic t_reset_state();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1", paid, 0, "paid during reset");
    rst = 1'b0;
    @(posedge clk); #1;
    check("R1", paid, 0, "paid after reset");
    probe("R1", 0);
  endtask

  // All totals crossed with all input combinations
  task automatic t_walk_table();
    for (int s = 0; s < 6; s++) begin
      for (int in = 0; in < 8; in++) begin
        int c = cents_of(s);
        bit d = in[0];
        bit q = in[1];
        bit r = in[2];
        int nxt = ref_next(c, d, q, r);
        string tg = tag_for(c, d, q, r);
        reach(c);
        check("R10", paid, (c == 35) ? 1 : 0, "paid at start total");
        step(d, q, r);
        check(tg, paid, (nxt == 35) ? 1 : 0, "paid after input");
        probe(tg, nxt);
      end
    end
  endtask

  // R10 and R11: exact cycle of paid, no reaction inside a cycle
  task automatic t_timing();
    reach(0);
    step(1, 0, 0); step(1, 0, 0); step(1, 0, 0);
    check("R10", paid, 0, "paid at 30 cents");
    @(negedge clk);
    dime = 1'b1;
    #1;
    check("R11", paid, 0, "paid before edge with dime high");
    @(posedge clk); #1;
    dime = 1'b0;
    check("R11", paid, 1, "paid after edge registering fourth dime");
    reach(20);
    @(negedge clk);
    quarter = 1'b1;
    #1;
    check("R11", paid, 0, "paid before edge with quarter high");
    @(posedge clk); #1;
    quarter = 1'b0;
    check("R6", paid, 1, "paid after quarter from 20");
  endtask

  // R8 and R3: long saturation run with idle gaps
  task automatic t_saturation();
    reach(35);
    for (int k = 0; k < 6; k++) begin
      step(k[0], ~k[0], 0);
      check("R8", paid, 1, "paid under repeated coins");
      step(0, 0, 0);
      check("R3", paid, 1, "paid over idle cycle");
    end
    step(0, 0, 1);
    check("R2", paid, 0, "paid after reset from 35");
    probe("R2", 0);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #100000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    t_reset_state();
    t_walk_table();
    t_timing();
    t_saturation();
    report();
  end

endmodule